// File: doc/BRIEF.md
# Branch Mispredict Kill Controller

This block decides which in-flight instructions are squashed when a branch resolves as mispredicted in a six-stage in-order pipeline (fetch, decode, issue, execute 0, execute 1, writeback). The pipeline may issue one or three instructions per group. Each cycle the block sees the valid bit and PC of every slot in fetch through execute 1. It also sees a per-slot mispredict flag with a correct target from the execute-1 group. It returns one kill bit per slot, a fetch redirect with its PC, and the number of entries killed. The pipeline registers clear the killed valid bits on the same clock edge on which fetch takes the new PC.

A parameter enables one architectural delay slot. The instruction that follows the branch in program order must then survive, wherever it sits. If it has not been fetched yet, the block first sends fetch to the sequential address for a single instruction. It holds the real target and redirects to it once that instruction shows up in fetch. All pins are plain control and status signals with no back-pressure. The block is purely combinational from its inputs, apart from the waiting state of the delay-slot sequence.

Top module: `mispredict_flush_unit`

## Requirements
- R1: After reset, with all inputs low, no kill bit and no redirect is asserted and the kill count is 0.
- R2: With no valid mispredicting slot in execute 1 and no delay-slot wait in progress, all kill bits, the redirect and the count are 0.
- R3: Entries are indexed stage*W+slot with stage 0=fetch, 1=decode, 2=issue, 3=execute 0, 4=execute 1. Slot 0 is the oldest of its group, and execute 1 is older than all earlier stages. On a mispredict, every valid entry younger than the branch is killed, including younger execute-1 slots. Older entries are never killed.
- R4: The kill count equals the number of asserted kill bits. With three slots, full stages and no delay slot, it is 14 for a branch in slot 0 and 12 for a branch in slot 2.
- R5: On a mispredict without the delay-slot sequence, the redirect is asserted in the same cycle with the correct target and the single-fetch flag low.
- R6: When several execute-1 slots flag a mispredict, only the lowest (oldest) valid one is acted on, and its target is used.
- R7: With the delay slot enabled, the first valid entry younger than the branch is spared when its PC equals branch PC + 4, wherever it sits. Full three-wide maxima then become 13 (slot 0) and 11 (slot 2).
- R8: With the delay slot enabled and no such entry present, all younger entries are killed. The redirect goes to branch PC + 4 with the single-fetch flag high, and a wait begins.
- R9: While waiting, resolution inputs are ignored. When a fetch slot holds branch PC + 4, the valid fetch slots above it are killed and fetch is redirected to the held target with the single-fetch flag low, ending the wait.
- R10: An entry whose valid bit is low is never killed.
- R11: A mispredict flag on an invalid execute-1 slot has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| stg_vld | input | 5*W | valid bit per stage and slot (index stage*W+slot) |
| stg_pc | input | 5*W*PC_W | PC per stage and slot, same indexing |
| res_mispredict | input | W | per execute-1 slot mispredict flag |
| res_target | input | W*PC_W | per execute-1 slot correct target |
| kill | output | 5*W | per-entry kill, applied at the next edge |
| kill_cnt | output | CNT_W | number of asserted kill bits |
| redir_vld | output | 1 | fetch redirect request |
| redir_pc | output | PC_W | fetch redirect address |
| fetch_one | output | 1 | fetch only one instruction from the redirect address |

## Verification
Kills, the count and the redirect are combinational. They are due in the same cycle as the inputs that cause them, so the bench drives on the falling edge and compares a little later, before the rising edge. The only state is the delay-slot wait. It begins at the rising edge that ends the cycle with a single-fetch redirect and shapes results from the next cycle. The reference model commits its own wait state at that same rising edge. Two instances, with and without the delay slot, are checked against the model every cycle under directed and random stimulus.

// File: rtl/kc_pkg.sv
package kc_pkg;
  // stages seen by the controller, youngest first
  typedef enum int {STG_F = 0, STG_D = 1, STG_I = 2, STG_X0 = 3, STG_X1 = 4} stage_e;
  localparam int NSTG = 5;

  // program-order rank (0 = oldest) to flat entry index stage*w+slot
  function automatic int rank_to_entry(int r, int w);
    return (NSTG - 1 - r / w) * w + (r % w);
  endfunction
endpackage

// File: rtl/kc_oldest.sv
module kc_oldest #(
  parameter int W      = 3,
  parameter int PC_W   = 32,
  localparam int SLOT_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]      x1_vld,
  input  logic [W*PC_W-1:0] x1_pc,
  input  logic [W-1:0]      misp,
  input  logic [W*PC_W-1:0] tgt,
  output logic              fire,
  output logic [SLOT_W-1:0] slot,
  output logic [PC_W-1:0]   br_pc,
  output logic [PC_W-1:0]   br_tgt
);
  // scan from youngest to oldest so the oldest flagged slot is kept
  always_comb begin
    fire   = 1'b0;
    slot   = '0;
    br_pc  = '0;
    br_tgt = '0;
    for (int s = W - 1; s >= 0; s--) begin
      if (x1_vld[s] && misp[s]) begin
        fire   = 1'b1;
        slot   = SLOT_W'(s);
        br_pc  = x1_pc[s*PC_W +: PC_W];
        br_tgt = tgt[s*PC_W +: PC_W];
      end
    end
  end
endmodule

// File: rtl/kc_select.sv
module kc_select
  import kc_pkg::*;
#(
  parameter int W          = 3,
  parameter int PC_W       = 32,
  parameter int DELAY_SLOT = 0,
  parameter int STEP       = 4,
  localparam int NE        = NSTG * W,
  localparam int SLOT_W    = (W > 1) ? $clog2(W) : 1
) (
  input  logic              fire,
  input  logic [SLOT_W-1:0] slot,
  input  logic [PC_W-1:0]   br_pc,
  input  logic [NE-1:0]     vld,
  input  logic [NE*PC_W-1:0] pc,
  output logic [NE-1:0]     kill,
  output logic              ds_missing
);
  logic seen, spared;

  // walk entries in program order; the branch is execute-1 rank `slot`
  always_comb begin
    kill   = '0;
    seen   = 1'b0;
    spared = 1'b0;
    for (int r = 0; r < NE; r++) begin
      if (fire && r > int'(slot) && vld[rank_to_entry(r, W)]) begin
        if (!seen && DELAY_SLOT != 0 &&
            pc[rank_to_entry(r, W)*PC_W +: PC_W] == br_pc + PC_W'(STEP))
          spared = 1'b1;
        else
          kill[rank_to_entry(r, W)] = 1'b1;
        seen = 1'b1;
      end
    end
    ds_missing = fire && (DELAY_SLOT != 0) && !spared;
  end
endmodule

// File: rtl/kc_redirect.sv
module kc_redirect #(
  parameter int W    = 3,
  parameter int PC_W = 32,
  parameter int STEP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [PC_W-1:0]   br_pc,
  input  logic [PC_W-1:0]   br_tgt,
  input  logic              ds_missing,
  input  logic [W-1:0]      f_vld,
  input  logic [W*PC_W-1:0] f_pc,
  output logic              redir_vld,
  output logic [PC_W-1:0]   redir_pc,
  output logic              fetch_one,
  output logic [W-1:0]      f_kill,
  output logic              waiting
);
  logic [PC_W-1:0] held_tgt, ds_pc;
  logic            hit;

  always_comb begin
    redir_vld = 1'b0;
    redir_pc  = '0;
    fetch_one = 1'b0;
    f_kill    = '0;
    hit       = 1'b0;
    if (waiting) begin
      for (int s = 0; s < W; s++) begin
        if (hit && f_vld[s]) f_kill[s] = 1'b1;
        if (!hit && f_vld[s] && f_pc[s*PC_W +: PC_W] == ds_pc) hit = 1'b1;
      end
      if (hit) begin
        redir_vld = 1'b1;
        redir_pc  = held_tgt;
      end
    end else if (fire) begin
      redir_vld = 1'b1;
      if (ds_missing) begin
        redir_pc  = br_pc + PC_W'(STEP);
        fetch_one = 1'b1;
      end else begin
        redir_pc  = br_tgt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      waiting  <= 1'b0;
      held_tgt <= '0;
      ds_pc    <= '0;
    end else if (waiting) begin
      if (hit) waiting <= 1'b0;
    end else if (fire && ds_missing) begin
      waiting  <= 1'b1;
      held_tgt <= br_tgt;
      ds_pc    <= br_pc + PC_W'(STEP);
    end
  end
endmodule

// File: rtl/mispredict_flush_unit.sv
module mispredict_flush_unit
  import kc_pkg::*;
#(
  parameter int W          = 3,
  parameter int PC_W       = 32,
  parameter int DELAY_SLOT = 0,
  parameter int STEP       = 4,
  localparam int NE        = NSTG * W,
  localparam int CNT_W     = $clog2(NE),
  localparam int SLOT_W    = (W > 1) ? $clog2(W) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NE-1:0]     stg_vld,
  input  logic [NE*PC_W-1:0] stg_pc,
  input  logic [W-1:0]      res_mispredict,
  input  logic [W*PC_W-1:0] res_target,
  output logic [NE-1:0]     kill,
  output logic [CNT_W-1:0]  kill_cnt,
  output logic              redir_vld,
  output logic [PC_W-1:0]   redir_pc,
  output logic              fetch_one
);
  localparam int X1_BASE = int'(STG_X1) * W;

  logic              fire_raw, fire, ds_missing, waiting_q;
  logic [SLOT_W-1:0] br_slot;
  logic [PC_W-1:0]   br_pc, br_tgt;
  logic [NE-1:0]     sel_kill;
  logic [W-1:0]      f_kill;

  kc_oldest #(.W(W), .PC_W(PC_W)) i_oldest (
    .x1_vld (stg_vld[X1_BASE +: W]),
    .x1_pc  (stg_pc[X1_BASE*PC_W +: W*PC_W]),
    .misp   (res_mispredict),
    .tgt    (res_target),
    .fire   (fire_raw),
    .slot   (br_slot),
    .br_pc  (br_pc),
    .br_tgt (br_tgt)
  );

  // resolutions are ignored while a delay-slot fetch is outstanding
  assign fire = fire_raw & ~waiting_q;

  kc_select #(.W(W), .PC_W(PC_W), .DELAY_SLOT(DELAY_SLOT), .STEP(STEP)) i_select (
    .fire       (fire),
    .slot       (br_slot),
    .br_pc      (br_pc),
    .vld        (stg_vld),
    .pc         (stg_pc),
    .kill       (sel_kill),
    .ds_missing (ds_missing)
  );

  kc_redirect #(.W(W), .PC_W(PC_W), .STEP(STEP)) i_redirect (
    .clk        (clk),
    .rst        (rst),
    .fire       (fire),
    .br_pc      (br_pc),
    .br_tgt     (br_tgt),
    .ds_missing (ds_missing),
    .f_vld      (stg_vld[W-1:0]),
    .f_pc       (stg_pc[W*PC_W-1:0]),
    .redir_vld  (redir_vld),
    .redir_pc   (redir_pc),
    .fetch_one  (fetch_one),
    .f_kill     (f_kill),
    .waiting    (waiting_q)
  );

  assign kill = sel_kill | {{(NE-W){1'b0}}, f_kill};

  always_comb begin
    kill_cnt = '0;
    for (int e = 0; e < NE; e++) kill_cnt = kill_cnt + CNT_W'(kill[e]);
  end
endmodule

// File: rtl/mispredict_flush_unit_chk.sv
module mispredict_flush_unit_chk #(
  parameter int W     = 3,
  parameter int NE    = 15,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [NE-1:0]    stg_vld,
  input logic [W-1:0]     res_mispredict,
  input logic [NE-1:0]    kill,
  input logic [CNT_W-1:0] kill_cnt,
  input logic             redir_vld,
  input logic             fetch_one,
  input logic             waiting
);
  a_r10_bubbles_kept: assert property (@(posedge clk) disable iff (rst)
    (kill & ~stg_vld) == '0);

  a_r4_count_ceiling: assert property (@(posedge clk) disable iff (rst)
    int'(kill_cnt) <= NE - 1);

  a_r3_oldest_slot_kept: assert property (@(posedge clk) disable iff (rst)
    !kill[(NE/W - 1)*W]);

  a_r5_kill_has_redirect: assert property (@(posedge clk) disable iff (rst)
    (|kill) |-> redir_vld);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!waiting && (res_mispredict & stg_vld[(NE/W - 1)*W +: W]) == '0)
      |-> (!redir_vld && kill == '0));

  a_r8_single_starts_wait: assert property (@(posedge clk) disable iff (rst)
    (redir_vld && fetch_one) |=> waiting);

  a_r9_no_second_single: assert property (@(posedge clk) disable iff (rst)
    (redir_vld && fetch_one) |=> !(redir_vld && fetch_one));
endmodule

bind mispredict_flush_unit mispredict_flush_unit_chk #(.W(W), .NE(NE), .CNT_W(CNT_W)) i_chk (
  .clk            (clk),
  .rst            (rst),
  .stg_vld        (stg_vld),
  .res_mispredict (res_mispredict),
  .kill           (kill),
  .kill_cnt       (kill_cnt),
  .redir_vld      (redir_vld),
  .fetch_one      (fetch_one),
  .waiting        (waiting_q)
);

// File: tb/test_mispredict_flush_unit.sv
module test_mispredict_flush_unit;
  localparam int W = 3, NE = 15, PW = 32;

  logic clk = 1'b0, rst = 1'b1;
  always #5 clk = ~clk;

  logic [NE-1:0]    stg_vld = '0;
  logic [NE*PW-1:0] stg_pc = '0;
  logic [W-1:0]     res_mispredict = '0;
  logic [W*PW-1:0]  res_target = '0;

  logic [NE-1:0] k0, k1;
  logic [3:0]    c0, c1;
  logic          rv0, rv1, one0, one1;
  logic [PW-1:0] rp0, rp1;

  mispredict_flush_unit #(.W(W), .PC_W(PW), .DELAY_SLOT(0)) i_mispredict_flush_unit (
    .clk(clk), .rst(rst), .stg_vld(stg_vld), .stg_pc(stg_pc),
    .res_mispredict(res_mispredict), .res_target(res_target),
    .kill(k0), .kill_cnt(c0), .redir_vld(rv0), .redir_pc(rp0), .fetch_one(one0));

  mispredict_flush_unit #(.W(W), .PC_W(PW), .DELAY_SLOT(1)) i_mispredict_flush_unit_ds (
    .clk(clk), .rst(rst), .stg_vld(stg_vld), .stg_pc(stg_pc),
    .res_mispredict(res_mispredict), .res_target(res_target),
    .kill(k1), .kill_cnt(c1), .redir_vld(rv1), .redir_pc(rp1), .fetch_one(one1));

  int checks = 0, errors = 0;
  logic [NE-1:0] vld_a;
  logic [PW-1:0] pc_a [NE];
  logic [W-1:0]  mis_a;
  logic [PW-1:0] tg_a [W];

  // reference state per instance
  bit            m_wait [2];
  logic [PW-1:0] m_held [2], m_dspc [2];
  int            ord [$];
  // values sampled from the design in the last step
  int            s_cnt [2];
  logic          s_rv [2], s_one [2];
  logic [PW-1:0] s_pc [2];

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference for one instance (d=1: delay slot on)
  task automatic model(input int d, output logic [NE-1:0] ek, output logic erv,
                       output logic [PW-1:0] epc, output logic eone,
                       output bit nw, output logic [PW-1:0] nh, output logic [PW-1:0] nd);
    int b;
    bit first, spared;
    ek = '0; erv = 0; epc = '0; eone = 0; nw = m_wait[d]; nh = m_held[d]; nd = m_dspc[d];
    if (m_wait[d]) begin
      int hitslot = -1;
      for (int s = 0; s < W; s++) begin
        if (hitslot >= 0 && vld_a[s]) ek[s] = 1;
        if (hitslot < 0 && vld_a[s] && pc_a[s] == m_dspc[d]) hitslot = s;
      end
      if (hitslot >= 0) begin erv = 1; epc = m_held[d]; nw = 0; end
      return;
    end
    b = -1;
    for (int s = 0; s < W; s++)
      if (b < 0 && vld_a[12+s] && mis_a[s]) b = s;
    if (b < 0) return;
    first = 1; spared = 0;
    foreach (ord[p]) begin
      if (p > b && vld_a[ord[p]]) begin
        if (first && d == 1 && pc_a[ord[p]] == pc_a[12+b] + 4) spared = 1;
        else ek[ord[p]] = 1;
        first = 0;
      end
    end
    erv = 1;
    if (d == 1 && !spared) begin
      epc = pc_a[12+b] + 4; eone = 1; nw = 1; nh = tg_a[b]; nd = pc_a[12+b] + 4;
    end else epc = tg_a[b];
  endtask

  task automatic step();
    logic [NE-1:0] ek; logic erv, eone; logic [PW-1:0] epc;
    bit nw [2]; logic [PW-1:0] nh [2], nd [2];
    @(negedge clk);
    stg_vld = vld_a; res_mispredict = mis_a;
    for (int e = 0; e < NE; e++) stg_pc[e*PW +: PW] = pc_a[e];
    for (int s = 0; s < W; s++) res_target[s*PW +: PW] = tg_a[s];
    #2;
    for (int d = 0; d < 2; d++) begin
      model(d, ek, erv, epc, eone, nw[d], nh[d], nd[d]);
      s_cnt[d] = (d == 0) ? int'(c0) : int'(c1);
      s_rv[d]  = (d == 0) ? rv0 : rv1;
      s_pc[d]  = (d == 0) ? rp0 : rp1;
      s_one[d] = (d == 0) ? one0 : one1;
      chk($sformatf("R3 R7 R9 R10 kill vector inst%0d", d), (d == 0) ? k0 : k1, ek);
      chk($sformatf("R4 kill count inst%0d", d), s_cnt[d], $countones(ek));
      chk($sformatf("R5 R8 redirect valid inst%0d", d), s_rv[d], erv);
      if (erv) chk($sformatf("R5 R6 redirect pc inst%0d", d), s_pc[d], epc);
      chk($sformatf("R8 single fetch inst%0d", d), s_one[d], eone);
    end
    @(posedge clk);
    for (int d = 0; d < 2; d++) begin m_wait[d] = nw[d]; m_held[d] = nh[d]; m_dspc[d] = nd[d]; end
  endtask

  // PCs rise by 4 per valid entry in program order
  task automatic fill(logic [PW-1:0] base);
    int n = 0;
    foreach (ord[p]) begin
      if (vld_a[ord[p]]) begin pc_a[ord[p]] = base + PW'(4 * n); n++; end
      else pc_a[ord[p]] = $urandom;
    end
  endtask

  task automatic quiet();
    vld_a = '0; mis_a = '0;
    for (int e = 0; e < NE; e++) pc_a[e] = '0;
    for (int s = 0; s < W; s++) tg_a[s] = '0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int st = 4; st >= 0; st--) for (int s = 0; s < W; s++) ord.push_back(st*W + s);
    for (int d = 0; d < 2; d++) begin m_wait[d] = 0; m_held[d] = '0; m_dspc[d] = '0; end
    quiet();
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // R1: quiet after reset
    step();
    chk("R1 no redirect after reset", s_rv[0] | s_rv[1], 0);
    chk("R1 zero count after reset", s_cnt[0] + s_cnt[1], 0);

    // R2: full pipe, no mispredict
    vld_a = '1; fill(32'h1000);
    step();
    chk("R2 no kills without mispredict", s_cnt[0] + s_cnt[1], 0);

    // R4 R5 R7: branch in oldest slot
    mis_a = 3'b001; tg_a[0] = 32'h8000;
    step();
    chk("R4 max count slot0 no delay slot", s_cnt[0], 14);
    chk("R5 target same cycle", s_pc[0], 32'h8000);
    chk("R7 max count slot0 delay slot", s_cnt[1], 13);

    // R4 R7: branch in youngest slot
    mis_a = 3'b100; tg_a[2] = 32'h9000;
    step();
    chk("R4 max count slot2 no delay slot", s_cnt[0], 12);
    chk("R7 max count slot2 delay slot", s_cnt[1], 11);

    // R6: two mispredicts, oldest wins
    mis_a = 3'b110; tg_a[1] = 32'hA000; tg_a[2] = 32'hB000;
    step();
    chk("R6 oldest target used", s_pc[0], 32'hA000);
    chk("R6 count from oldest branch", s_cnt[0], 13);

    // R7 R10: bubbles, delay slot sitting in issue
    vld_a = '0; vld_a[14:12] = 3'b111; vld_a[6] = 1'b1; vld_a[2:0] = 3'b111;
    fill(32'h2000); mis_a = 3'b100; tg_a[2] = 32'hC000;
    step();
    chk("R10 bubbles not counted", s_cnt[0], 4);
    chk("R7 delay slot in issue spared", s_cnt[1], 3);

    // R11: flag on invalid slot
    vld_a = '1; vld_a[13] = 1'b0; fill(32'h3000); mis_a = 3'b010;
    step();
    chk("R11 invalid slot ignored", s_rv[0] | s_rv[1], 0);

    // R8: delay slot not yet fetched
    vld_a = '0; vld_a[12] = 1'b1; pc_a[12] = 32'h4000; mis_a = 3'b001; tg_a[0] = 32'hD000;
    step();
    chk("R8 sequential redirect pc", s_pc[1], 32'h4004);
    chk("R8 single fetch flag", s_one[1], 1);

    // R9: waiting, fetch without the delay slot, with an ignored resolution
    vld_a[2:0] = 3'b011; pc_a[0] = 32'h5000; pc_a[1] = 32'h5004;
    step();
    chk("R9 no redirect before delay slot arrives", s_rv[1], 0);

    // R9: delay slot arrives in fetch slot 0
    vld_a[2:0] = 3'b111; pc_a[0] = 32'h4004; pc_a[1] = 32'h4008; pc_a[2] = 32'h400C;
    step();
    chk("R9 held target used", s_pc[1], 32'hD000);
    chk("R9 younger fetch slots killed", s_cnt[1], 2);
    chk("R9 single flag low", s_one[1], 0);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      vld_a = NE'($urandom) | NE'($urandom);
      fill($urandom & 32'hFFFF_FFFC);
      mis_a = ($urandom % 3 == 0) ? W'($urandom) : '0;
      for (int s = 0; s < W; s++) tg_a[s] = $urandom;
      if ($urandom % 7 == 0) pc_a[$urandom % NE] = $urandom;
      if (m_wait[1] && $urandom % 2 == 0) begin
        int s = $urandom % W;
        vld_a[s] = 1'b1; pc_a[s] = m_dspc[1];
      end
      step();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule